// File: doc/BRIEF.md
# Supply Undervoltage Event Escalation Counter

This block counts how often the main logic supply falls below its undervoltage threshold, and asks the system to enter fail-safe mode once the supply has dropped out too often in a row. An already debounced undervoltage indication comes in as a level. The block detects its rising edge, so one long dip counts as one event and not as many. Every detected dip sets a status bit that software reads and later clears.

The counter only runs in the operating modes where repeated dips point to a real supply problem: Init, Normal and Stop. In Normal mode it also holds its value while the battery supply is itself under its own limit, because a dip on the logic supply is then expected. When the counter reaches the limit, the block sends a one-cycle request for fail-safe entry and sets a sticky flag that records the cause. Three events return the counter to zero:
- confirmation that fail-safe mode was entered;
- a software clear of the status bit;
- a soft reset.

All pins are plain control and status signals. No data stream passes through the block, so it has no handshake.

Top module: `uv_escalate`

## Requirements
- R1: A rising edge on `uv_evt_i` is one event. When counting is enabled, the count rises by one in the cycle after the edge. A level held high for several cycles counts only once.
- R2: Counting is enabled only when `mode_i` is Init (code 0), Normal (code 1) or Stop (code 2). Events in Fail-Safe (code 3) or Restart (code 4) leave the count unchanged.
- R3: In Normal mode with `batt_low_i` high, events leave the count unchanged. In Init and Stop modes `batt_low_i` has no effect.
- R4: The event that brings the count to LIMIT (default 4) raises `fs_req_o` for exactly one cycle, in the same cycle that the count shows LIMIT.
- R5: The count saturates at LIMIT and never wraps. Further events at LIMIT give no new request.
- R6: `fs_cause_o` is set together with each `fs_req_o` pulse. Once set, it is cleared only by `cause_clr_i`. A new request in the same cycle as `cause_clr_i` keeps it set.
- R7: `fs_entered_i` clears the count to zero in the next cycle.
- R8: `stat_clr_i` clears both the count and `uv_stat_o` in the next cycle.
- R9: `soft_rst_i` clears the count in the next cycle and leaves `uv_stat_o` unchanged.
- R10: Every detected event sets `uv_stat_o` in any mode, and it stays set until `stat_clr_i`.
- R11: If any of the three count clears arrives in the same cycle as an event, the clear wins. The event is not counted and no request is raised. A status clear also wins over the status set.
- R12: After reset, the count is zero and all three flag outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uv_evt_i | input | 1 | Debounced supply undervoltage level |
| mode_i | input | 3 | Current mode: 0 Init, 1 Normal, 2 Stop, 3 Fail-Safe, 4 Restart |
| batt_low_i | input | 1 | Battery supply below its undervoltage limit |
| stat_clr_i | input | 1 | Software clear of the status bit (also clears the count) |
| soft_rst_i | input | 1 | Soft reset strobe (clears the count) |
| fs_entered_i | input | 1 | Fail-safe mode has been entered (clears the count) |
| cause_clr_i | input | 1 | Software clear of the sticky cause flag |
| fs_req_o | output | 1 | One-cycle fail-safe entry request |
| fs_cause_o | output | 1 | Sticky flag: fail-safe was caused by repeated undervoltage |
| uv_stat_o | output | 1 | Undervoltage status bit |
| uv_cnt_o | output | $clog2(LIMIT+1) (3) | Current event count |

## Verification
The bench builds the block with the default LIMIT of 4, so the count reaches saturation and the fail-safe request within a handful of pulses. That leaves room in one short run to walk every mode code, the battery freeze and each clear source against a counter at an intermediate value and at its ceiling. The 3-bit count width at this limit also makes a wrap past LIMIT visible on the port.

// File: rtl/uv_esc_pkg.sv
package uv_esc_pkg;
  typedef enum logic [2:0] {
    MODE_INIT     = 3'd0,
    MODE_NORMAL   = 3'd1,
    MODE_STOP     = 3'd2,
    MODE_FAILSAFE = 3'd3,
    MODE_RESTART  = 3'd4
  } sbc_mode_e;
endpackage

// File: rtl/uv_edge_det.sv
module uv_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;

  // A detected edge cannot repeat in the next cycle
  AST_ONE_EDGE_PER_EPISODE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o); // R1
endmodule

// File: rtl/uv_mode_gate.sv
module uv_mode_gate
  import uv_esc_pkg::*;
#(
  parameter int MODE_W = 3
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic              batt_low_i,
  output logic              count_en_o
);
  logic mode_ok;
  logic frozen;

  always_comb begin
    mode_ok = (mode_i == MODE_W'(MODE_INIT))   ||
              (mode_i == MODE_W'(MODE_NORMAL)) ||
              (mode_i == MODE_W'(MODE_STOP));
    frozen  = (mode_i == MODE_W'(MODE_NORMAL)) && batt_low_i;
    count_en_o = mode_ok && !frozen;
  end
endmodule

// File: rtl/uv_esc_counter.sv
module uv_esc_counter #(
  parameter int LIMIT = 4,
  localparam int CNT_W = $clog2(LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  input  logic             count_en_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o
);
  localparam logic [CNT_W-1:0] TOP  = CNT_W'(LIMIT);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic step;

  assign step  = rise_i && count_en_i && !clr_i && (cnt_o != TOP);
  assign hit_o = step && (cnt_o == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (step)  cnt_o <= cnt_o + 1'b1;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_o <= TOP); // R5
  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_o == '0)); // R11
  AST_HOLD_WHEN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_en_i && !clr_i) |=> $stable(cnt_o)); // R2
  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_i && count_en_i && !clr_i && cnt_o < TOP) |=> (cnt_o == $past(cnt_o) + 1'b1)); // R1
endmodule

// File: rtl/uv_esc_flags.sv
module uv_esc_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_i,
  input  logic hit_i,
  input  logic stat_clr_i,
  input  logic cause_clr_i,
  output logic fs_req_o,
  output logic fs_cause_o,
  output logic uv_stat_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_req_o   <= 1'b0;
      fs_cause_o <= 1'b0;
      uv_stat_o  <= 1'b0;
    end else begin
      fs_req_o <= hit_i;
      if (hit_i)            fs_cause_o <= 1'b1;
      else if (cause_clr_i) fs_cause_o <= 1'b0;
      if (stat_clr_i)       uv_stat_o  <= 1'b0;
      else if (rise_i)      uv_stat_o  <= 1'b1;
    end
  end

  AST_REQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    fs_req_o |=> !fs_req_o); // R4
  AST_REQ_SETS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    fs_req_o |-> fs_cause_o); // R6
  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_cause_o && !cause_clr_i) |=> fs_cause_o); // R6
  AST_STAT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clr_i |=> !uv_stat_o); // R8
  AST_STAT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_i && !stat_clr_i) |=> uv_stat_o); // R10
endmodule

// File: rtl/uv_escalate.sv
module uv_escalate #(
  parameter int LIMIT  = 4,
  parameter int MODE_W = 3,
  localparam int CNT_W = $clog2(LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              uv_evt_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              batt_low_i,
  input  logic              stat_clr_i,
  input  logic              soft_rst_i,
  input  logic              fs_entered_i,
  input  logic              cause_clr_i,
  output logic              fs_req_o,
  output logic              fs_cause_o,
  output logic              uv_stat_o,
  output logic [CNT_W-1:0]  uv_cnt_o
);
  logic rise;
  logic count_en;
  logic clr_any;
  logic hit;

  assign clr_any = fs_entered_i | stat_clr_i | soft_rst_i;

  uv_edge_det u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (uv_evt_i),
    .rise_o (rise)
  );

  uv_mode_gate #(.MODE_W(MODE_W)) u_gate (
    .mode_i     (mode_i),
    .batt_low_i (batt_low_i),
    .count_en_o (count_en)
  );

  uv_esc_counter #(.LIMIT(LIMIT)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .rise_i     (rise),
    .count_en_i (count_en),
    .clr_i      (clr_any),
    .cnt_o      (uv_cnt_o),
    .hit_o      (hit)
  );

  uv_esc_flags u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .rise_i      (rise),
    .hit_i       (hit),
    .stat_clr_i  (stat_clr_i),
    .cause_clr_i (cause_clr_i),
    .fs_req_o    (fs_req_o),
    .fs_cause_o  (fs_cause_o),
    .uv_stat_o   (uv_stat_o)
  );

  AST_REQ_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    fs_req_o |-> (uv_cnt_o == CNT_W'(LIMIT))); // R4
  AST_CLR_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    clr_any |=> !fs_req_o); // R11
endmodule

// File: tb/tb_uv_escalate.sv
module tb_uv_escalate;
  import uv_esc_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       uv_evt_i = 1'b0;
  logic [2:0] mode_i = MODE_INIT;
  logic       batt_low_i = 1'b0;
  logic       stat_clr_i = 1'b0;
  logic       soft_rst_i = 1'b0;
  logic       fs_entered_i = 1'b0;
  logic       cause_clr_i = 1'b0;
  logic       fs_req_o, fs_cause_o, uv_stat_o;
  logic [2:0] uv_cnt_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uv_escalate dut (
    .clk(clk), .rst_n(rst_n), .uv_evt_i(uv_evt_i), .mode_i(mode_i),
    .batt_low_i(batt_low_i), .stat_clr_i(stat_clr_i), .soft_rst_i(soft_rst_i),
    .fs_entered_i(fs_entered_i), .cause_clr_i(cause_clr_i),
    .fs_req_o(fs_req_o), .fs_cause_o(fs_cause_o), .uv_stat_o(uv_stat_o),
    .uv_cnt_o(uv_cnt_o)
  );

  typedef struct packed {
    logic       evt;
    logic [2:0] mode;
    logic       batt;
    logic       sclr;
    logic       srst;
    logic       fse;
    logic       cclr;
    logic [2:0] cnt;
    logic       req;
    logic       cause;
    logic       stat;
    logic [3:0] rq;
  } vec_t;

  localparam logic O = 1'b0;
  localparam logic I = 1'b1;
  localparam logic [2:0] MI = MODE_INIT;
  localparam logic [2:0] MN = MODE_NORMAL;
  localparam logic [2:0] MS = MODE_STOP;
  localparam logic [2:0] MF = MODE_FAILSAFE;
  localparam logic [2:0] MR = MODE_RESTART;
  localparam int NV = 28;

  // evt mode batt sclr srst fse cclr | cnt req cause stat | requirement
  localparam vec_t VEC [NV] = '{
    '{I, MI, O, O, O, O, O, 3'd1, O, O, I, 4'd1},  // R1 first edge counts
    '{O, MI, O, O, O, O, O, 3'd1, O, O, I, 4'd10}, // R10 status stays
    '{I, MN, O, O, O, O, O, 3'd2, O, O, I, 4'd2},  // R2 Normal counts
    '{I, MN, O, O, O, O, O, 3'd2, O, O, I, 4'd1},  // R1 held level
    '{O, MN, O, O, O, O, O, 3'd2, O, O, I, 4'd1},
    '{I, MS, I, O, O, O, O, 3'd3, O, O, I, 4'd3},  // R3 battery ignored in Stop
    '{O, MS, I, O, O, O, O, 3'd3, O, O, I, 4'd3},
    '{I, MN, I, O, O, O, O, 3'd3, O, O, I, 4'd3},  // R3 frozen in Normal
    '{O, MN, I, O, O, O, O, 3'd3, O, O, I, 4'd3},
    '{I, MF, O, O, O, O, O, 3'd3, O, O, I, 4'd2},  // R2 Fail-Safe ignored
    '{O, MF, O, O, O, O, O, 3'd3, O, O, I, 4'd2},
    '{I, MR, O, O, O, O, O, 3'd3, O, O, I, 4'd2},  // R2 Restart ignored
    '{O, MR, O, O, O, O, O, 3'd3, O, O, I, 4'd2},
    '{I, MI, O, O, O, O, O, 3'd4, I, I, I, 4'd4},  // R4 fourth event
    '{O, MI, O, O, O, O, O, 3'd4, O, I, I, 4'd4},  // R4 single pulse
    '{I, MI, O, O, O, O, O, 3'd4, O, I, I, 4'd5},  // R5 saturates
    '{O, MI, O, O, O, O, O, 3'd4, O, I, I, 4'd5},
    '{O, MI, O, I, O, O, O, 3'd0, O, I, O, 4'd8},  // R8 status clear, R6 cause kept
    '{O, MI, O, O, O, O, I, 3'd0, O, O, O, 4'd6},  // R6 cause clear
    '{I, MI, O, O, O, O, O, 3'd1, O, O, I, 4'd10}, // R10 status set again
    '{O, MI, O, O, O, O, O, 3'd1, O, O, I, 4'd1},
    '{I, MI, O, O, O, I, O, 3'd0, O, O, I, 4'd11}, // R11 clear beats event
    '{O, MI, O, O, O, O, O, 3'd0, O, O, I, 4'd11},
    '{I, MN, O, O, O, O, O, 3'd1, O, O, I, 4'd1},
    '{O, MN, O, O, O, I, O, 3'd0, O, O, I, 4'd7},  // R7 fail-safe entered
    '{I, MN, O, O, O, O, O, 3'd1, O, O, I, 4'd1},
    '{O, MN, O, O, I, O, O, 3'd0, O, O, I, 4'd9},  // R9 soft reset keeps status
    '{I, MN, O, I, O, O, O, 3'd0, O, O, O, 4'd11}  // R11 status clear beats set
  };

  task automatic drive(input vec_t v);
    uv_evt_i = v.evt; mode_i = v.mode; batt_low_i = v.batt;
    stat_clr_i = v.sclr; soft_rst_i = v.srst; fs_entered_i = v.fse;
    cause_clr_i = v.cclr;
  endtask

  task automatic check(input string tag, input logic [2:0] ec, input logic er,
                       input logic ecs, input logic es);
    n_checks++;
    if (uv_cnt_o !== ec || fs_req_o !== er || fs_cause_o !== ecs || uv_stat_o !== es) begin
      n_errors++;
      $display("FAIL %s: got cnt=%0d req=%b cause=%b stat=%b, expected cnt=%0d req=%b cause=%b stat=%b",
               tag, uv_cnt_o, fs_req_o, fs_cause_o, uv_stat_o, ec, er, ecs, es);
    end
  endtask

  task automatic step_pulse(input logic sclr, input logic srst);
    @(negedge clk);
    uv_evt_i = 1'b1; stat_clr_i = sclr; soft_rst_i = srst;
    @(negedge clk);
    uv_evt_i = 1'b0; stat_clr_i = 1'b0; soft_rst_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R12 reset state", 3'd0, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      @(posedge clk);
      #1;
      check($sformatf("R%0d row %0d", VEC[i].rq, i), VEC[i].cnt, VEC[i].req,
            VEC[i].cause, VEC[i].stat);
    end

    // Directed: reset mid-state returns everything to zero
    @(negedge clk);
    uv_evt_i = 1'b0; stat_clr_i = 1'b0;
    step_pulse(1'b0, 1'b0);
    rst_n = 1'b0;
    #1;
    check("R12 reset after activity", 3'd0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    // R11: the fourth edge arrives with a status clear -> no request
    mode_i = MODE_INIT;
    for (int k = 0; k < 3; k++) step_pulse(1'b0, 1'b0);
    #1;
    check("R11 three counted", 3'd3, 1'b0, 1'b0, 1'b1);
    step_pulse(1'b1, 1'b0);
    #1;
    check("R11 fourth with status clear", 3'd0, 1'b0, 1'b0, 1'b0);

    // R11: the fourth edge arrives with a soft reset -> no request, status set
    for (int k = 0; k < 3; k++) step_pulse(1'b0, 1'b0);
    step_pulse(1'b0, 1'b1);
    #1;
    check("R11 fourth with soft reset", 3'd0, 1'b0, 1'b0, 1'b1);

    // R6: a new request in the same cycle as the cause clear keeps the flag
    for (int k = 0; k < 3; k++) step_pulse(1'b0, 1'b0);
    @(negedge clk);
    uv_evt_i = 1'b1; cause_clr_i = 1'b1;
    @(posedge clk);
    #1;
    check("R6 request beats cause clear", 3'd4, 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    uv_evt_i = 1'b0; cause_clr_i = 1'b0;

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule